// File: doc/BRIEF.md
# Stereo Digital Automatic Level Control

This block adjusts the gain of a stereo digital playback stream one sample at a time. Each strobed left/right pair is multiplied by a coefficient picked by a 7-bit gain index. The index covers -12 dB to +35.625 dB in 0.375 dB steps. The product is saturated to 24 bits and registered.

The larger magnitude of the two scaled samples is compared with a programmable target. Sustained excess lowers the gain after a programmable attack interval. Sustained shortfall raises it after a programmable decay interval. The gain always stays between a programmable floor and ceiling.

A peak limiter cannot be switched off. Optional zero-cross gating delays normal gain moves to a sign change, with a timeout. An optional fast-release mode shortens recovery after a large impulse. When the control is switched off, the gain sits at the programmed ceiling.

Top module: `alc_top`

## Requirements
- R1: One cycle after a sample is strobed on `in_valid`, `out_valid` is high and each output equals floor(x * M(k%16) * 2^(k/16) / 2^16). Here k is `gain_idx` before that sample, and M(j) = round(2^(j/16) * 16384). Index 32 is unity gain and index 0 is a quarter. In cycles with no strobe, `out_valid` is low and `gain_idx` does not change.
- R2: A scaled value beyond the signed 24-bit range is clamped to 8388607 or -8388608.
- R3: With `cfg_en` low, any sample whose scaled level is at or below the peak limit leaves `gain_idx` equal to `cfg_max_gain`.
- R4: If the larger scaled magnitude of a sample exceeds 7340032 (7/8 of full scale), the gain drops by one step on that sample, unless it is already at `cfg_min_gain`. This happens whether the control is on or off, and regardless of zero-cross gating.
- R5: With the control on, once the scaled level exceeds `cfg_target` on `cfg_atk_ivl` consecutive samples since the last gain change, the gain drops by one step. The scaled level is the larger absolute value of the two channels.
- R6: With the control on, once the scaled level is below `cfg_target` on `cfg_dec_ivl` consecutive samples since the last gain change, the gain rises by one step.
- R7: After every sample, `gain_idx` lies within [`cfg_min_gain`, `cfg_max_gain`]. A gain left outside a newly narrowed range is pulled to the nearer bound on the next sample.
- R8: With `cfg_zc_en` high, a due attack or decay step waits for a sample whose left input is zero or has the opposite sign to the previous left input.
- R9: A step waiting on a crossing is applied anyway on the sample where the number of earlier waiting samples reaches `cfg_zc_timeout`.
- R10: With `cfg_fr_en` high, a sample whose scaled level exceeds `cfg_fr_thr` selects `cfg_fr_ivl` as the decay interval. This lasts until the gain is back at `cfg_max_gain`.
- R11: During and straight after reset, `out_valid` is 0, both outputs are 0 and `gain_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| cfg_en | input | 1 | Level control on |
| cfg_zc_en | input | 1 | Zero-cross gating on |
| cfg_fr_en | input | 1 | Fast release on |
| cfg_max_gain | input | 7 | Gain ceiling index |
| cfg_min_gain | input | 7 | Gain floor index |
| cfg_target | input | 24 | Target level, unsigned magnitude |
| cfg_fr_thr | input | 24 | Fast-release trigger level |
| cfg_atk_ivl | input | 8 | Attack interval in samples |
| cfg_dec_ivl | input | 8 | Decay interval in samples |
| cfg_fr_ivl | input | 8 | Fast decay interval in samples |
| cfg_zc_timeout | input | 8 | Zero-cross wait limit in samples |
| out_valid | output | 1 | Scaled sample strobe |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| gain_idx | output | 7 | Gain index for the next sample |

## Verification
The scaled samples, `out_valid` and the updated `gain_idx` are all due one clock after the edge that captures a strobed sample. The bench drives each sample on a falling edge and holds the strobe for one cycle. It reads every result on the next falling edge, which is half a cycle after that capture edge.

Gain sequences are predicted by counting samples against the programmed intervals. Scaled values are recomputed from the power-of-two formula in real arithmetic. A sweep over all 128 gain indices uses small, large and extreme samples.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int OCT_BITS   = 4;   // 16 gain steps per doubling
  localparam int MANT_W     = 15;
  localparam int MANT_FRAC  = 14;
  localparam int LOW_OCT    = 2;   // index 0 sits two doublings below unity
  localparam int NORM_SHIFT = MANT_FRAC + LOW_OCT;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_t;

  // round(2^(k/16) * 2^14)
  function automatic logic [MANT_W-1:0] mant_lut(input logic [OCT_BITS-1:0] k);
    case (k)
      4'd0:    return 15'd16384;
      4'd1:    return 15'd17109;
      4'd2:    return 15'd17867;
      4'd3:    return 15'd18658;
      4'd4:    return 15'd19484;
      4'd5:    return 15'd20347;
      4'd6:    return 15'd21247;
      4'd7:    return 15'd22188;
      4'd8:    return 15'd23170;
      4'd9:    return 15'd24196;
      4'd10:   return 15'd25268;
      4'd11:   return 15'd26386;
      4'd12:   return 15'd27554;
      4'd13:   return 15'd28774;
      4'd14:   return 15'd30048;
      default: return 15'd31379;
    endcase
  endfunction
endpackage

// File: rtl/alc_gain_mult.sv
module alc_gain_mult
  import alc_pkg::*;
#(
  parameter int DW = 24,
  parameter int GW = 7
) (
  input  logic signed [DW-1:0] x,
  input  logic        [GW-1:0] g,
  output logic signed [DW-1:0] y
);
  localparam int EW = GW - OCT_BITS;
  localparam int PW = DW + MANT_W + 1 + (1 << EW);
  localparam logic signed [PW-1:0] POS_LIM = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] NEG_LIM = -PW'(64'sd1 <<< (DW - 1));

  logic        [MANT_W-1:0] mant;
  logic signed [PW-1:0]     xe, me, prod, scl;

  always_comb begin
    mant = mant_lut(g[OCT_BITS-1:0]);
    xe   = {{(PW-DW){x[DW-1]}}, x};
    me   = $signed({{(PW-MANT_W){1'b0}}, mant});
    prod = xe * me;
    scl  = (prod <<< g[GW-1:OCT_BITS]) >>> NORM_SHIFT;
    if (scl > POS_LIM)      y = POS_LIM[DW-1:0];
    else if (scl < NEG_LIM) y = NEG_LIM[DW-1:0];
    else                    y = scl[DW-1:0];
  end
endmodule

// File: rtl/alc_level_det.sv
module alc_level_det #(
  parameter int DW  = 24,
  parameter int NCH = 2
) (
  input  logic signed [DW-1:0] y [NCH],
  output logic        [DW-1:0] lvl
);
  logic [DW-1:0] mag;

  always_comb begin
    lvl = '0;
    mag = '0;
    for (int i = 0; i < NCH; i++) begin
      mag = y[i][DW-1] ? DW'(-y[i]) : DW'(y[i]);
      if (mag > lvl) lvl = mag;
    end
  end
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int DW = 24,
  parameter int GW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] lvl,
  input  logic          zc_hit,
  input  logic          en,
  input  logic          zc_en,
  input  logic          fr_en,
  input  logic [GW-1:0] gmax,
  input  logic [GW-1:0] gmin,
  input  logic [DW-1:0] target,
  input  logic [DW-1:0] fr_thr,
  input  logic [CW-1:0] atk_ivl,
  input  logic [CW-1:0] dec_ivl,
  input  logic [CW-1:0] fr_ivl,
  input  logic [CW-1:0] zc_to,
  output logic [GW-1:0] gain
);
  localparam logic [DW-1:0] PEAK_LIM = DW'(((64'd1 << (DW - 1)) / 64'd8) * 64'd7);
  localparam logic [CW-1:0] CNT_MAX  = '1;

  dir_t          dir_q, dir_now;
  logic [CW-1:0] cnt_q, cnt_nx, wait_q, ivl;
  logic          fast_q, peak, req, go;
  logic [GW-1:0] raw, gnext;

  always_comb begin
    peak = lvl > PEAK_LIM;
    if (lvl > target)      dir_now = DIR_DOWN;
    else if (lvl < target) dir_now = DIR_UP;
    else                   dir_now = DIR_HOLD;

    if (dir_now == DIR_HOLD)     cnt_nx = '0;
    else if (dir_now != dir_q)   cnt_nx = CW'(1);
    else if (cnt_q == CNT_MAX)   cnt_nx = cnt_q;
    else                         cnt_nx = cnt_q + CW'(1);

    if (dir_now == DIR_DOWN) ivl = atk_ivl;
    else if (fast_q)         ivl = fr_ivl;
    else                     ivl = dec_ivl;

    req = (dir_now != DIR_HOLD) && (cnt_nx >= ivl);
    go  = req && (!zc_en || zc_hit || (wait_q >= zc_to));

    raw = gain;
    if (peak) begin
      if (gain > gmin) raw = gain - GW'(1);
    end else if (!en) begin
      raw = gmax;
    end else if (go) begin
      if (dir_now == DIR_DOWN) begin
        if (gain > gmin) raw = gain - GW'(1);
      end else if (gain < gmax) begin
        raw = gain + GW'(1);
      end
    end

    gnext = raw;
    if (gnext < gmin) gnext = gmin;
    if (gnext > gmax) gnext = gmax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain   <= '0;
      dir_q  <= DIR_HOLD;
      cnt_q  <= '0;
      wait_q <= '0;
      fast_q <= 1'b0;
    end else if (smp_valid) begin
      gain  <= gnext;
      dir_q <= dir_now;
      if (peak || !en || go) begin
        cnt_q  <= '0;
        wait_q <= '0;
      end else begin
        cnt_q <= cnt_nx;
        if (!req)                  wait_q <= '0;
        else if (wait_q != CNT_MAX) wait_q <= wait_q + CW'(1);
      end
      if (!fr_en)             fast_q <= 1'b0;
      else if (lvl > fr_thr)  fast_q <= 1'b1;
      else if (gnext == gmax) fast_q <= 1'b0;
    end
  end
endmodule

// File: rtl/alc_top.sv
module alc_top #(
  parameter int DW = 24,
  parameter int GW = 7,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_r,
  input  logic          cfg_en,
  input  logic          cfg_zc_en,
  input  logic          cfg_fr_en,
  input  logic [GW-1:0] cfg_max_gain,
  input  logic [GW-1:0] cfg_min_gain,
  input  logic [DW-1:0] cfg_target,
  input  logic [DW-1:0] cfg_fr_thr,
  input  logic [CW-1:0] cfg_atk_ivl,
  input  logic [CW-1:0] cfg_dec_ivl,
  input  logic [CW-1:0] cfg_fr_ivl,
  input  logic [CW-1:0] cfg_zc_timeout,
  output logic          out_valid,
  output logic [DW-1:0] out_l,
  output logic [DW-1:0] out_r,
  output logic [GW-1:0] gain_idx
);
  localparam int NCH = 2;

  logic signed [DW-1:0] x_ch [NCH];
  logic signed [DW-1:0] y_ch [NCH];
  logic        [DW-1:0] lvl;
  logic                 prev_neg_q, zc_hit;

  assign x_ch[0] = in_l;
  assign x_ch[1] = in_r;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    alc_gain_mult #(.DW(DW), .GW(GW)) u_mult (
      .x (x_ch[c]),
      .g (gain_idx),
      .y (y_ch[c])
    );
  end

  alc_level_det #(.DW(DW), .NCH(NCH)) u_lvl (
    .y   (y_ch),
    .lvl (lvl)
  );

  assign zc_hit = (in_l == '0) || (in_l[DW-1] != prev_neg_q);

  alc_gain_ctrl #(.DW(DW), .GW(GW), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (in_valid),
    .lvl       (lvl),
    .zc_hit    (zc_hit),
    .en        (cfg_en),
    .zc_en     (cfg_zc_en),
    .fr_en     (cfg_fr_en),
    .gmax      (cfg_max_gain),
    .gmin      (cfg_min_gain),
    .target    (cfg_target),
    .fr_thr    (cfg_fr_thr),
    .atk_ivl   (cfg_atk_ivl),
    .dec_ivl   (cfg_dec_ivl),
    .fr_ivl    (cfg_fr_ivl),
    .zc_to     (cfg_zc_timeout),
    .gain      (gain_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_l      <= '0;
      out_r      <= '0;
      prev_neg_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_l      <= y_ch[0];
        out_r      <= y_ch[1];
        prev_neg_q <= in_l[DW-1];
      end
    end
  end
endmodule

// File: rtl/alc_chk.sv
module alc_chk #(
  parameter int DW = 24,
  parameter int GW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          cfg_en,
  input logic [GW-1:0] cfg_max_gain,
  input logic [GW-1:0] cfg_min_gain,
  input logic          out_valid,
  input logic [DW-1:0] out_l,
  input logic [DW-1:0] out_r,
  input logic [GW-1:0] gain_idx
);
  localparam logic [DW-1:0] LIM = DW'(((64'd1 << (DW - 1)) / 64'd8) * 64'd7);

  function automatic logic [DW-1:0] mag(input logic [DW-1:0] v);
    return v[DW-1] ? (~v + DW'(1)) : v;
  endfunction

  logic peak_out;
  assign peak_out = (mag(out_l) > LIM) || (mag(out_r) > LIM);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R1
  gain_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(gain_idx));

  // R7
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cfg_min_gain <= cfg_max_gain))
    |=> ((gain_idx >= $past(cfg_min_gain)) && (gain_idx <= $past(cfg_max_gain))));

  // R3
  off_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_en && (cfg_min_gain <= cfg_max_gain))
    |=> (peak_out || (gain_idx == $past(cfg_max_gain))));

  // R4
  limiter_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (gain_idx > cfg_min_gain) && (gain_idx <= cfg_max_gain))
    |=> (!peak_out || (gain_idx == $past(gain_idx) - GW'(1))));
endmodule

bind alc_top alc_chk #(.DW(DW), .GW(GW)) u_alc_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .cfg_en       (cfg_en),
  .cfg_max_gain (cfg_max_gain),
  .cfg_min_gain (cfg_min_gain),
  .out_valid    (out_valid),
  .out_l        (out_l),
  .out_r        (out_r),
  .gain_idx     (gain_idx)
);

// File: tb/test_alc_top.sv
module test_alc_top;
  localparam int DW = 24;
  localparam int GW = 7;
  localparam int CW = 8;
  localparam longint LIM = 7340032;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_l = '0, in_r = '0;
  logic          cfg_en = 1'b0, cfg_zc_en = 1'b0, cfg_fr_en = 1'b0;
  logic [GW-1:0] cfg_max_gain = '0, cfg_min_gain = '0;
  logic [DW-1:0] cfg_target = '0, cfg_fr_thr = '0;
  logic [CW-1:0] cfg_atk_ivl = '0, cfg_dec_ivl = '0, cfg_fr_ivl = '0, cfg_zc_timeout = '0;
  logic          out_valid;
  logic [DW-1:0] out_l, out_r;
  logic [GW-1:0] gain_idx;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  alc_top #(.DW(DW), .GW(GW), .CW(CW)) i_alc_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .cfg_en(cfg_en), .cfg_zc_en(cfg_zc_en), .cfg_fr_en(cfg_fr_en),
    .cfg_max_gain(cfg_max_gain), .cfg_min_gain(cfg_min_gain),
    .cfg_target(cfg_target), .cfg_fr_thr(cfg_fr_thr),
    .cfg_atk_ivl(cfg_atk_ivl), .cfg_dec_ivl(cfg_dec_ivl),
    .cfg_fr_ivl(cfg_fr_ivl), .cfg_zc_timeout(cfg_zc_timeout),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .gain_idx(gain_idx)
  );

  function automatic longint exp_y(input longint x, input int g);
    longint m, p, y;
    m = longint'($rtoi((2.0 ** ((g % 16) / 16.0)) * 16384.0 + 0.5));
    p = x * m * (longint'(1) <<< (g / 16));
    y = p >>> 16;
    if (y > 8388607)  y = 8388607;
    if (y < -8388608) y = -8388608;
    return y;
  endfunction

  function automatic longint absv(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int l, input int r);
    @(negedge clk);
    in_l = l[DW-1:0];
    in_r = r[DW-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gain_is(input string req, input int exp);
    chk(req, longint'(gain_idx), longint'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int smp [8] = '{0, 1, -1, 12345, -777777, 8388607, -8388608, 3000000};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", out_valid, 0);
    chk("R11", out_l, 0);
    gain_is("R11", 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", out_valid, 0);
    gain_is("R11", 0);

    // R1 R2 R3 R4 sweep of every gain index, control off
    for (int g = 0; g < 128; g++) begin
      cfg_max_gain = GW'(g);
      for (int i = 0; i < 8; i++) begin
        longint el, er;
        bit pk, sat;
        push(0, 0);
        push(smp[i], smp[i] / 2);
        el  = exp_y(smp[i], g);
        er  = exp_y(smp[i] / 2, g);
        sat = (el == 8388607) || (el == -8388608);
        pk  = (absv(el) > LIM) || (absv(er) > LIM);
        chk("R1", out_valid, 1);
        chk(sat ? "R2" : "R1", longint'($signed(out_l)), el);
        chk("R1", longint'($signed(out_r)), er);
        gain_is(pk ? "R4" : "R3", pk ? ((g > 0) ? g - 1 : 0) : g);
      end
    end

    // R5 attack
    cfg_max_gain = 7'd48; cfg_min_gain = 7'd0;
    push(0, 0);
    gain_is("R3", 48);
    cfg_en = 1'b1; cfg_target = 24'd1000; cfg_atk_ivl = 8'd3; cfg_dec_ivl = 8'd5;
    push(10000, 10000); gain_is("R5", 48);
    push(10000, 10000); gain_is("R5", 48);
    push(10000, 10000); gain_is("R5", 47);
    push(10000, 10000); gain_is("R5", 47);
    push(10000, 10000); gain_is("R5", 47);
    push(10000, 10000); gain_is("R5", 46);

    // R6 decay and ceiling
    for (int i = 0; i < 4; i++) begin push(1, 1); gain_is("R6", 46); end
    push(1, 1); gain_is("R6", 47);
    cfg_dec_ivl = 8'd1;
    push(1, 1); gain_is("R6", 48);
    push(1, 1); gain_is("R7", 48);
    push(1, 1); gain_is("R7", 48);

    // R7 floor under attack
    cfg_min_gain = 7'd45; cfg_atk_ivl = 8'd1;
    push(10000, 10000); gain_is("R5", 47);
    push(10000, 10000); gain_is("R5", 46);
    push(10000, 10000); gain_is("R7", 45);
    push(10000, 10000); gain_is("R7", 45);

    // R4 limiter with control off, then on with zero-cross gating
    cfg_en = 1'b0; cfg_min_gain = 7'd40; cfg_zc_en = 1'b1; cfg_zc_timeout = 8'd15;
    push(0, 0); gain_is("R3", 48);
    push(4000000, 4000000);
    chk("R1", longint'($signed(out_l)), exp_y(4000000, 48));
    gain_is("R4", 47);
    push(4000000, 4000000); gain_is("R4", 46);
    push(4000000, 4000000);
    chk("R1", longint'($signed(out_l)), exp_y(4000000, 46));
    gain_is("R3", 48);
    cfg_en = 1'b1; cfg_target = 24'd8388608; cfg_dec_ivl = 8'd15;
    push(4000000, 4000000); gain_is("R4", 47);
    push(4000000, 4000000); gain_is("R4", 46);

    // R8 zero-cross and R9 timeout
    cfg_en = 1'b0; cfg_min_gain = 7'd0; cfg_zc_en = 1'b0;
    push(0, 0); gain_is("R3", 48);
    cfg_en = 1'b1; cfg_zc_en = 1'b1; cfg_zc_timeout = 8'd3;
    cfg_target = 24'd1000; cfg_atk_ivl = 8'd1;
    push(10000, 10000);   gain_is("R8", 48);
    push(10000, 10000);   gain_is("R8", 48);
    push(-10000, -10000); gain_is("R8", 47);
    push(-10000, -10000); gain_is("R9", 47);
    push(-10000, -10000); gain_is("R9", 47);
    push(-10000, -10000); gain_is("R9", 47);
    push(-10000, -10000); gain_is("R9", 46);

    // R10 fast release against normal decay
    cfg_en = 1'b0; cfg_zc_en = 1'b0;
    push(0, 0); gain_is("R3", 48);
    cfg_en = 1'b1; cfg_fr_en = 1'b1; cfg_fr_thr = 24'd6000000;
    cfg_dec_ivl = 8'd8; cfg_fr_ivl = 8'd1;
    push(3500000, 3500000); gain_is("R5", 47);
    push(1, 1);             gain_is("R10", 48);
    cfg_fr_en = 1'b0;
    push(3500000, 3500000); gain_is("R5", 47);
    push(1, 1);             gain_is("R10", 47);
    for (int i = 0; i < 6; i++) push(1, 1);
    gain_is("R6", 47);
    push(1, 1);             gain_is("R6", 48);

    // R1 no strobe, no change
    @(negedge clk);
    @(negedge clk);
    chk("R1", out_valid, 0);
    gain_is("R1", 48);

    // R7 ceiling lowered below the current gain
    cfg_max_gain = 7'd30;
    push(1, 1); gain_is("R7", 30);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule